// File: doc/BRIEF.md
# Processor exception entry sequencer

This block sits inside a processor core and carries out the hardware half of taking an exception. Three kinds of event can start an entry. A normal interrupt and a fast interrupt arrive as asynchronous request lines. A software trap arrives as a strobe from the decoder. The two request lines first pass through a chain of synchronizer flops. An entry then starts only at an instruction boundary, which the core marks with `instr_done_i`.

At that boundary the block records the return program counter and a copy of the current status word. In the two cycles that follow, it builds the handler status. This status has a new mode field and has the disable bits forced for the event. The block then issues a one-cycle redirect strobe, together with the fixed vector address of the event. The vector table starts at address 0. The handler code and the return path belong to the rest of the core.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is asserted and after it is released, `redirect_o` is 0 and `new_pc_o`, `new_sr_o`, `saved_pc_o` and `saved_sr_o` are all 0 until the first entry.
- R2: An external request passes through two synchronizer flops before it can be taken. With `instr_done_i` held at 1, a request raised before clock edge 1 gives `redirect_o` high after edge 5 and low after edge 4. The edges are: two to synchronize, one to capture, and two to enter.
- R3: An entry is only captured on a clock edge at which `instr_done_i` is 1. While it is 0, pending requests produce no redirect. After the boundary edge, `redirect_o` rises on the third edge.
- R4: At the capture edge, `saved_pc_o` takes `cur_pc_i` and `saved_sr_o` takes `cur_sr_i`. Both hold their values until the next capture.
- R5: A normal interrupt gives `new_pc_o` = 0x18. `new_sr_o` is the saved status with bits 4:0 set to 0x12 and bit 7 set. All other bits are unchanged.
- R6: A fast interrupt gives `new_pc_o` = 0x1C. `new_sr_o` is the saved status with bits 4:0 set to 0x11, and with bit 7 and bit 6 set. All other bits are unchanged.
- R7: A trap is taken only when `trap_i` and `instr_done_i` are both 1 on the same edge. It gives `new_pc_o` = 0x08. `new_sr_o` is the saved status with bits 4:0 set to 0x13 and bit 7 set. A trap strobe without the boundary is ignored.
- R8: When events coincide at a boundary, the order of priority is: trap first, then fast interrupt, then normal interrupt.
- R9: A normal request is ignored while bit 7 of `cur_sr_i` is 1. A fast request is ignored while bit 6 of `cur_sr_i` is 1. The trap cannot be masked.
- R10: `redirect_o` is a single-cycle pulse, issued together with fresh `new_pc_o` and `new_sr_o`. These two outputs hold their values when no redirect is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 1 | Asynchronous normal interrupt request, active high |
| fiq_req_i | input | 1 | Asynchronous fast interrupt request, active high |
| trap_i | input | 1 | Software trap strobe from the decoder |
| instr_done_i | input | 1 | Current instruction completes on this edge |
| cur_pc_i | input | PC_W | Return program counter offered by the core |
| cur_sr_i | input | SR_W | Current status word |
| redirect_o | output | 1 | One-cycle strobe: load new PC and status |
| new_pc_o | output | PC_W | Vector address of the event |
| new_sr_o | output | SR_W | Status word for the handler |
| saved_pc_o | output | PC_W | Saved return program counter |
| saved_sr_o | output | SR_W | Saved copy of the status word |

## Verification
The bench builds the block with its defaults: a 32-bit PC, a 32-bit status word, two synchronizer stages, and vectors 0x18, 0x1C and 0x08. With these values the exact five-edge request-to-redirect latency and the three-edge trap latency can be counted and checked. The bench keeps the upper status bits at nonzero patterns, so it can see that only the mode field and the disable bits change. It acts like the core and loads the handler status after each redirect, which brings masking by the freshly set disable bits into reach.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_IRQ  = 2'd1,
    EV_FIQ  = 2'd2,
    EV_TRAP = 2'd3
  } exc_ev_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SAVE  = 2'd1,
    ST_FORCE = 2'd2
  } exc_st_e;

  localparam int MODE_W   = 5;
  localparam int BIT_IDIS = 7;
  localparam int BIT_FDIS = 6;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
(
  input  logic    irq_s,
  input  logic    fiq_s,
  input  logic    trap,
  input  logic    done,
  input  logic    idis,
  input  logic    fdis,
  output exc_ev_e ev
);
  always_comb begin
    ev = EV_NONE;
    if (done) begin
      if (trap)               ev = EV_TRAP;
      else if (fiq_s && !fdis) ev = EV_FIQ;
      else if (irq_s && !idis) ev = EV_IRQ;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int          PC_W        = 32,
  parameter int          SR_W        = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] VEC_IRQ     = 32'h18,
  parameter logic [31:0] VEC_FIQ     = 32'h1C,
  parameter logic [31:0] VEC_TRAP    = 32'h08
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req_i,
  input  logic            fiq_req_i,
  input  logic            trap_i,
  input  logic            instr_done_i,
  input  logic [PC_W-1:0] cur_pc_i,
  input  logic [SR_W-1:0] cur_sr_i,
  output logic            redirect_o,
  output logic [PC_W-1:0] new_pc_o,
  output logic [SR_W-1:0] new_sr_o,
  output logic [PC_W-1:0] saved_pc_o,
  output logic [SR_W-1:0] saved_sr_o
);
  localparam int REQ_W = 2;

  logic [REQ_W-1:0] req_s;
  exc_ev_e          ev_sel, ev_q;
  exc_st_e          st_q, st_d;
  logic             cap_en, force_en;
  logic [PC_W-1:0]  vec_d;
  logic [SR_W-1:0]  nsr_d;

  exc_sync #(.STAGES(SYNC_STAGES), .W(REQ_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({fiq_req_i, irq_req_i}),
    .q     (req_s)
  );

  exc_arb u_arb (
    .irq_s (req_s[0]),
    .fiq_s (req_s[1]),
    .trap  (trap_i),
    .done  (instr_done_i),
    .idis  (cur_sr_i[BIT_IDIS]),
    .fdis  (cur_sr_i[BIT_FDIS]),
    .ev    (ev_sel)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (ev_sel != EV_NONE) st_d = ST_SAVE;
      ST_SAVE:  st_d = ST_FORCE;
      ST_FORCE: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign cap_en   = (st_q == ST_IDLE) && (ev_sel != EV_NONE);
  assign force_en = (st_q == ST_FORCE);

  // vector and handler status
  always_comb begin
    nsr_d = saved_sr_o;
    nsr_d[BIT_IDIS] = 1'b1;
    case (ev_q)
      EV_FIQ: begin
        vec_d = PC_W'(VEC_FIQ);
        nsr_d[MODE_W-1:0] = MODE_FIQ;
        nsr_d[BIT_FDIS] = 1'b1;
      end
      EV_TRAP: begin
        vec_d = PC_W'(VEC_TRAP);
        nsr_d[MODE_W-1:0] = MODE_SVC;
      end
      default: begin
        vec_d = PC_W'(VEC_IRQ);
        nsr_d[MODE_W-1:0] = MODE_IRQ;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ev_q       <= EV_NONE;
      saved_pc_o <= '0;
      saved_sr_o <= '0;
      new_pc_o   <= '0;
      new_sr_o   <= '0;
      redirect_o <= 1'b0;
    end else begin
      st_q       <= st_d;
      redirect_o <= force_en;
      if (cap_en) begin
        ev_q       <= ev_sel;
        saved_pc_o <= cur_pc_i;
        saved_sr_o <= cur_sr_i;
      end
      if (force_en) begin
        new_pc_o <= vec_d;
        new_sr_o <= nsr_d;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            redirect,
  input logic [PC_W-1:0] new_pc,
  input logic [PC_W-1:0] saved_pc,
  input logic [4:0]      mode,
  input logic [1:0]      dis
);
  // R10: single-cycle strobe
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  // R10: outputs hold without a redirect
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> $stable(new_pc) && $stable(mode) && $stable(dis));

  // R4: saved PC is not disturbed while the redirect is issued
  p_saved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> $stable(saved_pc));

  // R5 / R6 / R7: every entry sets the normal-disable bit
  p_idis_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> dis[1]);

  // R6: fast mode comes with both disable bits and its vector
  p_fiq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && mode == 5'h11) |-> (dis == 2'b11) && (new_pc == PC_W'(32'h1C)));

  // R7: supervisor mode comes with the trap vector
  p_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && mode == 5'h13) |-> (new_pc == PC_W'(32'h08)));
endmodule

bind exc_entry_seq exc_entry_chk #(.PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .redirect (redirect_o),
  .new_pc   (new_pc_o),
  .saved_pc (saved_pc_o),
  .mode     (new_sr_o[4:0]),
  .dis      (new_sr_o[7:6])
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;
  localparam int SR_W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic irq, fiq, trap, done;
  logic [PC_W-1:0] cur_pc;
  logic [SR_W-1:0] cur_sr;
  logic redirect;
  logic [PC_W-1:0] new_pc, saved_pc;
  logic [SR_W-1:0] new_sr, saved_sr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq), .fiq_req_i(fiq),
    .trap_i(trap), .instr_done_i(done), .cur_pc_i(cur_pc), .cur_sr_i(cur_sr),
    .redirect_o(redirect), .new_pc_o(new_pc), .new_sr_o(new_sr),
    .saved_pc_o(saved_pc), .saved_sr_o(saved_sr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // counts edges until redirect is seen, up to max; the core then loads the handler state
  task automatic wait_redirect(input int max, output int n);
    n = 0;
    for (int i = 0; i < max; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (redirect) begin
        cur_sr = new_sr;
        cur_pc = new_pc;
        return;
      end
    end
    n = -1;
  endtask

  task automatic settle(input logic [SR_W-1:0] sr);
    irq = 0; fiq = 0; trap = 0;
    repeat (5) @(negedge clk);
    cur_sr = sr;
  endtask

  function automatic logic [31:0] mk_sr(input logic [31:0] s, input logic [4:0] m, input logic fd);
    logic [31:0] r;
    r = s; r[4:0] = m; r[7] = 1'b1;
    if (fd) r[6] = 1'b1;
    return r;
  endfunction

  task automatic t_reset();
    check("R1 redirect", {31'd0, redirect}, 32'd0);
    check("R1 new_pc", new_pc, 32'd0);
    check("R1 new_sr", new_sr, 32'd0);
    check("R1 saved_pc", saved_pc, 32'd0);
    check("R1 saved_sr", saved_sr, 32'd0);
  endtask

  task automatic t_irq();
    int n;
    logic [31:0] sr0;
    settle(32'hA500_0010); sr0 = cur_sr;
    done = 1; cur_pc = 32'h0000_0100;
    irq = 1;
    wait_redirect(20, n);
    check("R2 irq latency", n, 5);
    check("R5 irq vector", new_pc, 32'h18);
    check("R5 irq status", new_sr, mk_sr(sr0, 5'h12, 1'b0));
    check("R4 saved pc", saved_pc, 32'h100);
    check("R4 saved sr", saved_sr, sr0);
    @(negedge clk);
    check("R10 one-cycle pulse", {31'd0, redirect}, 32'd0);
    check("R10 pc held", new_pc, 32'h18);
  endtask

  task automatic t_fiq();
    int n;
    logic [31:0] sr0;
    settle(32'h0F00_0010); sr0 = cur_sr;
    done = 1; cur_pc = 32'h0000_2000;
    fiq = 1;
    wait_redirect(20, n);
    check("R2 fiq latency", n, 5);
    check("R6 fiq vector", new_pc, 32'h1C);
    check("R6 fiq status", new_sr, mk_sr(sr0, 5'h11, 1'b1));
    check("R4 saved pc fiq", saved_pc, 32'h2000);
  endtask

  task automatic t_trap();
    int n;
    logic [31:0] sr0;
    settle(32'h1234_0010); sr0 = cur_sr;
    done = 1; cur_pc = 32'h0000_0444;
    trap = 1;
    @(posedge clk); @(negedge clk); trap = 0;
    wait_redirect(20, n);
    check("R7 trap latency", n + 1, 3);
    check("R7 trap vector", new_pc, 32'h08);
    check("R7 trap status", new_sr, mk_sr(sr0, 5'h13, 1'b0));
    check("R4 saved sr trap", saved_sr, sr0);
  endtask

  task automatic t_trap_no_boundary();
    int n;
    logic [31:0] pc0;
    settle(32'h0000_0010); pc0 = new_pc;
    done = 0; trap = 1;
    wait_redirect(8, n);
    check("R7 trap ignored without boundary", n, -1);
    check("R7 pc unchanged", new_pc, pc0);
    trap = 0;
  endtask

  task automatic t_mask();
    int n;
    logic [31:0] pc0;
    settle(32'h0000_0090); pc0 = new_pc;
    done = 1; irq = 1;
    wait_redirect(10, n);
    check("R9 irq masked", n, -1);
    settle(32'h0000_0050);
    done = 1; fiq = 1;
    wait_redirect(10, n);
    check("R9 fiq masked", n, -1);
    check("R10 pc held while masked", new_pc, pc0);
    settle(32'h0000_0050);
    done = 1; irq = 1;
    wait_redirect(10, n);
    check("R9 irq passes with only fast disabled", new_pc, 32'h18);
  endtask

  task automatic t_wait_boundary();
    int n;
    settle(32'h0000_0010);
    done = 0; irq = 1;
    wait_redirect(8, n);
    check("R3 no entry before boundary", n, -1);
    done = 1;
    @(posedge clk); @(negedge clk); done = 0;
    wait_redirect(10, n);
    check("R3 entry after boundary", n + 1, 3);
    check("R3 vector", new_pc, 32'h18);
  endtask

  task automatic t_prio();
    int n;
    settle(32'h0000_0010);
    done = 1; irq = 1; fiq = 1;
    wait_redirect(20, n);
    check("R8 fast over normal", new_pc, 32'h1C);
    settle(32'h0000_0010);
    done = 0; fiq = 1; irq = 1;
    repeat (3) @(negedge clk);
    done = 1; trap = 1;
    @(posedge clk); @(negedge clk); trap = 0; done = 0;
    wait_redirect(10, n);
    check("R8 trap over fast", new_pc, 32'h08);
    check("R8 trap mode", {27'd0, new_sr[4:0]}, 32'h13);
  endtask

  initial begin
    rst_n = 0; irq = 0; fiq = 0; trap = 0; done = 0;
    cur_pc = '0; cur_sr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_irq();
    t_fiq();
    t_trap();
    t_trap_no_boundary();
    t_mask();
    t_wait_boundary();
    t_prio();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule